// File: doc/BRIEF.md
# Sync activity and polarity monitor

This block sits in the front end of a video capture path. It watches four synchronized sync lines: horizontal sync, vertical sync, sync-on-green and coast. For each line it decides whether the line is toggling. For horizontal sync, vertical sync and coast it also measures which polarity the line has. The high and low phases are timed over one full input period, and the shorter phase is taken as the active pulse.

From the activity results and a control byte, the block picks the horizontal sync source (the dedicated pin or sync-on-green) and the vertical sync source (the dedicated pin or an externally separated vertical sync). It packs all results into one status byte, which is refreshed only at the end of each measurement window. It also drives registered copies of the two selected sync signals.

A shared timer sets the measurement window, and its length in clock cycles is a run-time input.

Top module: `sync_monitor`

## Requirements
- R1: A line held constantly high or constantly low reports an activity bit of 0 at every window end after the window in which it last changed (activity bits: status bit 7 hsync, bit 4 vsync, bit 1 sync-on-green).
- R2: A line with at least two synchronized edges inside one window of `win_len` cycles reports activity 1 at that window end. A line with at most one edge per window reports 0.
- R3: Polarity bits (status bit 5 hsync, bit 2 vsync, bit 0 coast) read 1 when the high phase of the last full period was shorter than the low phase, and 0 otherwise.
- R4: The hsync source bit (status bit 6; 0 = pin, 1 = sync-on-green) is 0 when only hsync is active, 1 when only sync-on-green is active, and equal to the hsync priority control bit (control bit 3) when both or neither are active.
- R5: When the hsync override control bit (control bit 4) is 1, status bit 6 equals control bit 3 whatever the activity.
- R6: Without override, the vsync source bit (status bit 3; 0 = pin, 1 = separated input) is 0 when vsync is active and 1 when it is not.
- R7: When the vsync override control bit (control bit 1) is 1, status bit 3 equals the vsync priority control bit (control bit 0).
- R8: The status byte is 0 after synchronous reset and changes only on the clock edge that closes a measurement window, so any two changes lie a whole number of windows apart.
- R9: `hsync_out` and `vsync_out` carry the synchronized line chosen by the current source bits, delayed by one register stage. Both are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync line |
| vsync_in | input | 1 | Vertical sync line |
| sog_in | input | 1 | Sync-on-green line |
| coast_in | input | 1 | Coast line |
| sepv_in | input | 1 | Vertical sync from an external separator |
| ctrl_reg | input | 8 | Control byte: bit 4 hsync override, bit 3 hsync priority, bit 1 vsync override, bit 0 vsync priority |
| win_len | input | CNT_W | Measurement window length in cycles (at least 2) |
| status | output | 8 | Packed activity, source and polarity results |
| hsync_out | output | 1 | Selected horizontal sync, registered |
| vsync_out | output | 1 | Selected vertical sync, registered |

## Verification
The bench toggles a line exactly once every 80 cycles and watches every cycle. A design that counts a single edge as activity would raise the activity bit at some point. It drives pulses with short and long high phases on hsync, vsync and coast. A design that inverts the shorter-phase rule, or that takes a level for a polarity, would report the wrong polarity bits. It covers every combination of hsync and sync-on-green activity with both priority values and with override. A design that treats "neither active" like "pin only" would pick the pin. It flips the priority bit in the middle of windows and checks that status changes lie whole windows apart. A design that lets the source bit follow the control byte at once would change status between window ends.

// File: rtl/sync_mon_pkg.sv
package sync_mon_pkg;

    localparam int CH_HS   = 0;
    localparam int CH_VS   = 1;
    localparam int CH_SOG  = 2;
    localparam int CH_CO   = 3;
    localparam int NUM_CH  = 4;

    localparam int CTRL_HS_OVR = 4;
    localparam int CTRL_HS_PRI = 3;
    localparam int CTRL_VS_OVR = 1;
    localparam int CTRL_VS_PRI = 0;

    typedef enum logic {HSRC_PIN = 1'b0, HSRC_SOG = 1'b1} hsrc_e;
    typedef enum logic {VSRC_PIN = 1'b0, VSRC_SEP = 1'b1} vsrc_e;

    // Packed MSB first: field order is the status bit order 7..0
    typedef struct packed {
        logic  hs_act;
        hsrc_e hs_sel;
        logic  hs_pol;
        logic  vs_act;
        vsrc_e vs_sel;
        logic  vs_pol;
        logic  sog_act;
        logic  co_pol;
    } status_t;

    typedef struct packed {
        logic hs_ovr;
        logic hs_pri;
        logic vs_ovr;
        logic vs_pri;
    } ctrl_t;

    typedef struct packed {
        logic act;
        logic pol;
    } chan_res_t;

    function automatic ctrl_t decode_ctrl(input logic [7:0] r);
        ctrl_t c;
        c.hs_ovr = r[CTRL_HS_OVR];
        c.hs_pri = r[CTRL_HS_PRI];
        c.vs_ovr = r[CTRL_VS_OVR];
        c.vs_pri = r[CTRL_VS_PRI];
        return c;
    endfunction

    function automatic hsrc_e pick_hsrc(input logic hs_act, input logic sog_act, input ctrl_t c);
        if (c.hs_ovr)
            return hsrc_e'(c.hs_pri);
        if (hs_act && !sog_act)
            return HSRC_PIN;
        if (!hs_act && sog_act)
            return HSRC_SOG;
        return hsrc_e'(c.hs_pri);
    endfunction

    function automatic vsrc_e pick_vsrc(input logic vs_act, input ctrl_t c);
        if (c.vs_ovr)
            return vsrc_e'(c.vs_pri);
        return vs_act ? VSRC_PIN : VSRC_SEP;
    endfunction

endpackage

// File: rtl/sync_mon_sync.sv
module sync_mon_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] sh;

    always_ff @(posedge clk) begin
        if (rst) sh <= '0;
        else     sh <= {sh[STAGES-2:0], d};
    end

    assign q = sh[STAGES-1];
endmodule

// File: rtl/sync_mon_window.sv
module sync_mon_window #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] win_len,
    output logic             win_end
);
    logic [CNT_W-1:0] cnt;

    assign win_end = (cnt >= win_len - 1'b1);

    always_ff @(posedge clk) begin
        if (rst)          cnt <= '0;
        else if (win_end) cnt <= '0;
        else              cnt <= cnt + 1'b1;
    end

    assert_win_restart_R8: assert property (@(posedge clk) disable iff (rst)
        win_end |=> (cnt == '0));
endmodule

// File: rtl/sync_mon_chan.sv
module sync_mon_chan
    import sync_mon_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int PER_W       = 16
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      din,
    input  logic      win_end,
    output logic      s_out,
    output chan_res_t res
);
    logic             s, prev;
    logic             edge_now, rise;
    logic [1:0]       ecnt, ecnt_nx;
    logic [PER_W-1:0] hi_cnt, lo_cnt;
    logic             seen_rise, pol_q;

    sync_mon_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst), .d(din), .q(s)
    );

    assign edge_now = s ^ prev;
    assign rise     = s & ~prev;
    // saturating edge count including the edge of this cycle
    assign ecnt_nx  = (ecnt == 2'd2) ? 2'd2 : ecnt + {1'b0, edge_now};

    always_ff @(posedge clk) begin
        if (rst) begin
            prev <= 1'b0;
            ecnt <= '0;
        end else begin
            prev <= s;
            ecnt <= win_end ? 2'd0 : ecnt_nx;
        end
    end

    // period measurement: restart on each rising edge
    always_ff @(posedge clk) begin
        if (rst) begin
            hi_cnt    <= '0;
            lo_cnt    <= '0;
            seen_rise <= 1'b0;
            pol_q     <= 1'b0;
        end else if (rise) begin
            if (seen_rise) pol_q <= (hi_cnt < lo_cnt);
            seen_rise <= 1'b1;
            hi_cnt    <= {{(PER_W-1){1'b0}}, 1'b1};
            lo_cnt    <= '0;
        end else if (s) begin
            if (hi_cnt != '1) hi_cnt <= hi_cnt + 1'b1;
        end else begin
            if (lo_cnt != '1) lo_cnt <= lo_cnt + 1'b1;
        end
    end

    assign s_out   = s;
    assign res.act = ecnt_nx[1];
    assign res.pol = pol_q;

    assert_edge_sat_R2: assert property (@(posedge clk) disable iff (rst)
        ecnt <= 2'd2);
    assert_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        (ecnt == 2'd0 && !edge_now) |-> !res.act);
endmodule

// File: rtl/sync_mon_arb.sv
module sync_mon_arb
    import sync_mon_pkg::*;
(
    input  logic  hs_act,
    input  logic  sog_act,
    input  logic  vs_act,
    input  ctrl_t ctrl,
    output hsrc_e hsrc,
    output vsrc_e vsrc
);
    always_comb begin
        hsrc = pick_hsrc(hs_act, sog_act, ctrl);
        vsrc = pick_vsrc(vs_act, ctrl);
    end
endmodule

// File: rtl/sync_monitor.sv
module sync_monitor
    import sync_mon_pkg::*;
#(
    parameter int CNT_W       = 16,
    parameter int PER_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             sog_in,
    input  logic             coast_in,
    input  logic             sepv_in,
    input  logic [7:0]       ctrl_reg,
    input  logic [CNT_W-1:0] win_len,
    output logic [7:0]       status,
    output logic             hsync_out,
    output logic             vsync_out
);
    logic [NUM_CH-1:0] din_vec, s_vec;
    chan_res_t         res [NUM_CH];
    logic              win_end, sepv_s;
    ctrl_t             ctrl;
    hsrc_e             hsrc_nx;
    vsrc_e             vsrc_nx;
    status_t           st_q, st_nx;

    assign din_vec[CH_HS]  = hsync_in;
    assign din_vec[CH_VS]  = vsync_in;
    assign din_vec[CH_SOG] = sog_in;
    assign din_vec[CH_CO]  = coast_in;
    assign ctrl            = decode_ctrl(ctrl_reg);

    sync_mon_window #(.CNT_W(CNT_W)) u_win (
        .clk(clk), .rst(rst), .win_len(win_len), .win_end(win_end)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chan
        sync_mon_chan #(.SYNC_STAGES(SYNC_STAGES), .PER_W(PER_W)) u_chan (
            .clk(clk), .rst(rst), .din(din_vec[i]), .win_end(win_end),
            .s_out(s_vec[i]), .res(res[i])
        );
    end

    sync_mon_sync #(.STAGES(SYNC_STAGES)) u_sepv_sync (
        .clk(clk), .rst(rst), .d(sepv_in), .q(sepv_s)
    );

    sync_mon_arb u_arb (
        .hs_act(res[CH_HS].act), .sog_act(res[CH_SOG].act),
        .vs_act(res[CH_VS].act), .ctrl(ctrl),
        .hsrc(hsrc_nx), .vsrc(vsrc_nx)
    );

    always_comb begin
        st_nx.hs_act  = res[CH_HS].act;
        st_nx.hs_sel  = hsrc_nx;
        st_nx.hs_pol  = res[CH_HS].pol;
        st_nx.vs_act  = res[CH_VS].act;
        st_nx.vs_sel  = vsrc_nx;
        st_nx.vs_pol  = res[CH_VS].pol;
        st_nx.sog_act = res[CH_SOG].act;
        st_nx.co_pol  = res[CH_CO].pol;
    end

    always_ff @(posedge clk) begin
        if (rst)          st_q <= '0;
        else if (win_end) st_q <= st_nx;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hsync_out <= 1'b0;
            vsync_out <= 1'b0;
        end else begin
            hsync_out <= (st_q.hs_sel == HSRC_SOG) ? s_vec[CH_SOG] : s_vec[CH_HS];
            vsync_out <= (st_q.vs_sel == VSRC_SEP) ? sepv_s : s_vec[CH_VS];
        end
    end

    assign status = st_q;

    assert_status_hold_R8: assert property (@(posedge clk) disable iff (rst)
        !win_end |=> $stable(status));
    assert_hs_override_R5: assert property (@(posedge clk) disable iff (rst)
        (win_end && ctrl_reg[4]) |=> (status[6] == $past(ctrl_reg[3])));
    assert_vs_override_R7: assert property (@(posedge clk) disable iff (rst)
        (win_end && ctrl_reg[1]) |=> (status[3] == $past(ctrl_reg[0])));
    assert_vs_select_R6: assert property (@(posedge clk) disable iff (rst)
        (win_end && !ctrl_reg[1]) |=> (status[3] == !status[4]));
    assert_hs_pin_only_R4: assert property (@(posedge clk) disable iff (rst)
        (win_end && !ctrl_reg[4]) |=> (!(status[7] && !status[1]) || !status[6]));
    assert_hout_pin_R9: assert property (@(posedge clk) disable iff (rst)
        (status[6] == 1'b0) |=> (hsync_out == $past(s_vec[CH_HS])));
endmodule

// File: tb/sync_monitor_bench.sv
module sync_monitor_bench;
    localparam int WIN = 64;

    logic        clk = 1'b0;
    logic        rst;
    logic        hsync_in, vsync_in, sog_in, coast_in, sepv_in;
    logic [7:0]  ctrl_reg;
    logic [15:0] win_len;
    logic [7:0]  status;
    logic        hsync_out, vsync_out;

    int checks = 0;
    int errors = 0;

    // generator settings: per==0 holds lvl, else period per with hi high cycles
    int hs_per = 0, hs_hi = 0, hs_ph = 0; logic hs_lvl = 1'b0;
    int vs_per = 0, vs_hi = 0, vs_ph = 0; logic vs_lvl = 1'b0;
    int sg_per = 0, sg_hi = 0, sg_ph = 0; logic sg_lvl = 1'b0;
    int co_per = 0, co_hi = 0, co_ph = 0; logic co_lvl = 1'b0;

    always #2 clk = ~clk;

    sync_monitor u_sync_monitor (
        .clk(clk), .rst(rst), .hsync_in(hsync_in), .vsync_in(vsync_in),
        .sog_in(sog_in), .coast_in(coast_in), .sepv_in(sepv_in),
        .ctrl_reg(ctrl_reg), .win_len(win_len), .status(status),
        .hsync_out(hsync_out), .vsync_out(vsync_out)
    );

    always @(posedge clk) begin
        if (hs_per == 0) hsync_in <= hs_lvl;
        else begin hsync_in <= (hs_ph < hs_hi); hs_ph <= (hs_ph + 1 >= hs_per) ? 0 : hs_ph + 1; end
        if (vs_per == 0) vsync_in <= vs_lvl;
        else begin vsync_in <= (vs_ph < vs_hi); vs_ph <= (vs_ph + 1 >= vs_per) ? 0 : vs_ph + 1; end
        if (sg_per == 0) sog_in <= sg_lvl;
        else begin sog_in <= (sg_ph < sg_hi); sg_ph <= (sg_ph + 1 >= sg_per) ? 0 : sg_ph + 1; end
        if (co_per == 0) coast_in <= co_lvl;
        else begin coast_in <= (co_ph < co_hi); co_ph <= (co_ph + 1 >= co_per) ? 0 : co_ph + 1; end
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic settle();
        repeat (3 * WIN + 10) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic set_all(input int hp, input int hh, input logic hl,
                           input int vp, input int vh, input logic vl,
                           input int sp, input int sh, input logic sl,
                           input int cp, input int ch, input logic cl);
        @(negedge clk);
        hs_per = hp; hs_hi = hh; hs_lvl = hl;
        vs_per = vp; vs_hi = vh; vs_lvl = vl;
        sg_per = sp; sg_hi = sh; sg_lvl = sl;
        co_per = cp; co_hi = ch; co_lvl = cl;
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk("R8 reset status", status, 8'h00);
        chk("R9 reset hsync_out", {7'b0, hsync_out}, 8'h00);
        chk("R9 reset vsync_out", {7'b0, vsync_out}, 8'h00);
    endtask

    task automatic t_idle();
        ctrl_reg = 8'h00;
        set_all(0, 0, 1'b1, 0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0);
        settle();
        chk("R1 hsync held high no activity", {7'b0, status[7]}, 8'h00);
        chk("R1 vsync held low no activity", {7'b0, status[4]}, 8'h00);
        chk("R1 sog held low no activity", {7'b0, status[1]}, 8'h00);
        chk("R6 no vsync selects separated", {7'b0, status[3]}, 8'h01);
    endtask

    task automatic t_polarity();
        ctrl_reg = 8'h00;
        set_all(16, 4, 1'b0, 40, 36, 1'b0, 0, 0, 1'b0, 16, 4, 1'b0);
        settle();
        chk("R2 hsync toggling active", {7'b0, status[7]}, 8'h01);
        chk("R2 vsync toggling active", {7'b0, status[4]}, 8'h01);
        chk("R3 short high hsync positive", {7'b0, status[5]}, 8'h01);
        chk("R3 long high vsync negative", {7'b0, status[2]}, 8'h00);
        chk("R3 short high coast positive", {7'b0, status[0]}, 8'h01);
        set_all(16, 12, 1'b0, 40, 4, 1'b0, 0, 0, 1'b0, 16, 12, 1'b0);
        settle();
        chk("R3 long high hsync negative", {7'b0, status[5]}, 8'h00);
        chk("R3 short high vsync positive", {7'b0, status[2]}, 8'h01);
        chk("R3 long high coast negative", {7'b0, status[0]}, 8'h00);
    endtask

    task automatic t_single_edges();
        int bad = 0;
        ctrl_reg = 8'h00;
        set_all(0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0);
        settle();
        for (int i = 0; i < 6 * 80; i++) begin
            if (i % 80 == 0) hs_lvl = ~hs_lvl;
            @(negedge clk);
            if (status[7]) bad++;
        end
        chk("R2 one edge per window never active", bad[7:0], 8'h00);
    endtask

    task automatic t_hsel();
        // hsync only
        set_all(16, 4, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0);
        ctrl_reg = 8'h08;
        settle();
        chk("R4 hsync only selects pin", {7'b0, status[6]}, 8'h00);
        // sog only
        set_all(0, 0, 1'b0, 0, 0, 1'b0, 16, 4, 1'b0, 0, 0, 1'b0);
        ctrl_reg = 8'h00;
        settle();
        chk("R4 sog only selects sog", {7'b0, status[6]}, 8'h01);
        chk("R2 sog toggling active", {7'b0, status[1]}, 8'h01);
        // both active
        set_all(16, 4, 1'b0, 0, 0, 1'b0, 16, 4, 1'b0, 0, 0, 1'b0);
        ctrl_reg = 8'h00;
        settle();
        chk("R4 both active priority 0", {7'b0, status[6]}, 8'h00);
        ctrl_reg = 8'h08;
        settle();
        chk("R4 both active priority 1", {7'b0, status[6]}, 8'h01);
        // neither
        set_all(0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0);
        ctrl_reg = 8'h08;
        settle();
        chk("R4 neither active priority 1", {7'b0, status[6]}, 8'h01);
    endtask

    task automatic t_hovr();
        set_all(0, 0, 1'b0, 0, 0, 1'b0, 16, 4, 1'b0, 0, 0, 1'b0);
        ctrl_reg = 8'h10;
        settle();
        chk("R5 override forces pin over sog", {7'b0, status[6]}, 8'h00);
        set_all(16, 4, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0);
        ctrl_reg = 8'h18;
        settle();
        chk("R5 override forces sog over hsync", {7'b0, status[6]}, 8'h01);
    endtask

    task automatic t_vsel();
        set_all(0, 0, 1'b0, 40, 4, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0);
        ctrl_reg = 8'h01;
        settle();
        chk("R6 vsync active selects pin", {7'b0, status[3]}, 8'h00);
        ctrl_reg = 8'h03;
        settle();
        chk("R7 override priority 1 selects separated", {7'b0, status[3]}, 8'h01);
        set_all(0, 0, 1'b0, 0, 0, 1'b1, 0, 0, 1'b0, 0, 0, 1'b0);
        ctrl_reg = 8'h02;
        settle();
        chk("R7 override priority 0 selects pin", {7'b0, status[3]}, 8'h00);
    endtask

    task automatic t_outputs();
        sepv_in = 1'b1;
        set_all(0, 0, 1'b1, 0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0);
        ctrl_reg = 8'h00;
        settle();
        chk("R9 hsync_out follows pin", {7'b0, hsync_out}, 8'h01);
        chk("R9 vsync_out follows separated", {7'b0, vsync_out}, 8'h01);
        ctrl_reg = 8'h0A;
        settle();
        chk("R9 hsync_out follows sog", {7'b0, hsync_out}, 8'h00);
        chk("R9 vsync_out follows pin under override", {7'b0, vsync_out}, 8'h00);
    endtask

    task automatic t_hold();
        int last = -1;
        int bad = 0;
        int changes = 0;
        logic [7:0] prev_st;
        set_all(0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0, 0, 0, 1'b0);
        ctrl_reg = 8'h00;
        settle();
        prev_st = status;
        for (int i = 0; i < 8 * WIN; i++) begin
            if (i % 23 == 0) ctrl_reg[3] = ~ctrl_reg[3];
            @(negedge clk);
            if (status !== prev_st) begin
                changes++;
                if (last >= 0 && ((i - last) % WIN) != 0) bad++;
                last = i;
                prev_st = status;
            end
        end
        chk("R8 status changes only at window ends", bad[7:0], 8'h00);
        chk("R8 status did update", {7'b0, (changes > 1)}, 8'h01);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1;
        sepv_in = 1'b0;
        ctrl_reg = 8'h00;
        win_len = 16'(WIN);
        repeat (5) @(posedge clk);
        @(negedge clk);
        t_reset();
        rst = 1'b0;
        t_reset();
        t_idle();
        t_polarity();
        t_single_edges();
        t_hsel();
        t_hovr();
        t_vsel();
        t_outputs();
        t_hold();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule